// File: doc/BRIEF.md
# Configurable Byte-Stuffing Frame Codec

This block frames and de-frames a byte stream in the style of serial-line packet framing. It has two independent paths. The encode path takes payload bytes with an end-of-frame marker and produces a line stream. Each frame is wrapped in a separator byte at its start and at its end. Any reserved byte inside the payload is replaced by a two-byte escape sequence. The decode path takes such a line stream and recovers the original payload. It removes separators, turns escape pairs back into the bytes they stand for, and marks the final byte of every frame.

Four reserved characters are handled: the separator, the escape character, XON and XOFF. Each one has a programmable value and a programmable two-byte replacement. Each has one enable bit for the encode path and one for the decode path. A single bit switches separator framing on or off. All of these settings arrive on configuration ports. The bench drives them with the default set held in the package: separator 0xC0, escape 0xDB, XON 0x11, XOFF 0x13, with replacements 0xDB followed by 0xDC, 0xDD, 0xDE and 0xDF in that order. Both paths use valid/ready byte streams with a last flag. Each path has a single output register, so every output is registered.

Top module: `slip_codec`

## Requirements
- R1: After reset, both output valids and the decode error flag are low.
- R2: With framing on, the encoder emits the separator before the first byte of a frame and again after its last byte. The out-last flag is set only on that closing separator.
- R3: When the encoder meets a byte that equals an encode-enabled reserved character, it emits that character's two replacement bytes in place of the byte. Index 0 is the separator, 1 the escape, 2 XON, 3 XOFF, and the lowest index wins a tie. After accepting such a byte, the encoder holds input ready low for exactly one cycle while the output is not stalled.
- R4: A reserved character whose encode enable is 0 passes through the encoder unchanged.
- R5: With framing off, the encoder emits no separators and sets out-last on the last payload byte (or on the second byte of its escape pair).
- R6: The decoder turns an enabled replacement pair back into its character. The first byte must match an enabled pair's first byte and the second byte must match that same pair's second byte.
- R7: With framing on, the decoder drops separators and sets out-last on the final payload byte of each frame. An empty frame, made of back-to-back separators, produces no output.
- R8: When an escape-start byte is followed by a byte that completes no enabled pair, the decoder raises its error flag for one cycle and passes both bytes on unchanged, in order.
- R9: A pair whose decode enable is 0 is not converted. If no enabled pair begins with its first byte, both bytes pass through with no error. Otherwise R8 applies.
- R10: While an output valid is high and its ready is low, data and last hold steady, and the decoder keeps its input ready low.
- R11: The separator value is taken from configuration: a non-default separator is used for framing, escaping and decoding.
- R12: A decoder input byte carrying the last flag ends the frame, so its decoded byte carries out-last. With framing off, separator values are ordinary data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_frame_en | input | 1 | Separator framing enable |
| cfg_chars | input | 4x8 | Reserved character values (0 separator, 1 escape, 2 XON, 3 XOFF) |
| cfg_seq_hi | input | 4x8 | First replacement byte per character |
| cfg_seq_lo | input | 4x8 | Second replacement byte per character |
| cfg_enc_en | input | 4 | Per-character encode enables |
| cfg_dec_en | input | 4 | Per-character decode enables |
| enc_in_valid | input | 1 | Encoder payload byte valid |
| enc_in_ready | output | 1 | Encoder accepts a byte |
| enc_in_data | input | 8 | Encoder payload byte |
| enc_in_last | input | 1 | Last payload byte of the frame |
| enc_out_valid | output | 1 | Encoded line byte valid |
| enc_out_ready | input | 1 | Downstream accepts an encoded byte |
| enc_out_data | output | 8 | Encoded line byte |
| enc_out_last | output | 1 | Final line byte of the frame |
| dec_in_valid | input | 1 | Decoder line byte valid |
| dec_in_ready | output | 1 | Decoder accepts a byte |
| dec_in_data | input | 8 | Decoder line byte |
| dec_in_last | input | 1 | Line byte ends the frame |
| dec_out_valid | output | 1 | Decoded payload byte valid |
| dec_out_ready | input | 1 | Downstream accepts a decoded byte |
| dec_out_data | output | 8 | Decoded payload byte |
| dec_out_last | output | 1 | Final payload byte of the frame |
| dec_err | output | 1 | One-cycle pulse on an unknown escape pair |

## Verification
An encoded byte is registered one cycle after its input is accepted. The decoder holds each decoded byte back until it knows whether the next event ends the frame, so its output trails the input by one accepted byte plus one register. An escape error shows on the flag one cycle after the stalled step that detects it. For this reason the bench compares whole output sequences, captured at every handshake, instead of fixed latencies. It counts error-flag cycles per scenario. It checks the one-cycle input stall of R3 from the cycle stamps of accepted bytes, which fall two cycles apart after an escaped byte and one cycle apart otherwise. Handshakes and the stall stability of R10 are sampled on the falling clock edge, where the values that the next rising edge will act on are settled.

// File: rtl/slip_pkg.sv
package slip_pkg;
    localparam int NUM_CHARS = 4;
    localparam int BYTE_W    = 8;

    // Character slots; the slot index is the tie-break priority
    localparam int SLOT_SEP  = 0;
    localparam int SLOT_ESC  = 1;
    localparam int SLOT_XON  = 2;
    localparam int SLOT_XOFF = 3;

    // Default configuration set
    localparam logic [NUM_CHARS-1:0][BYTE_W-1:0] DFLT_CHARS  = {8'h13, 8'h11, 8'hDB, 8'hC0};
    localparam logic [NUM_CHARS-1:0][BYTE_W-1:0] DFLT_SEQ_HI = {8'hDB, 8'hDB, 8'hDB, 8'hDB};
    localparam logic [NUM_CHARS-1:0][BYTE_W-1:0] DFLT_SEQ_LO = {8'hDF, 8'hDE, 8'hDD, 8'hDC};
endpackage

// File: rtl/slip_match.sv
// Masked parallel compare of a key against a table; lowest index wins.
module slip_match #(
    parameter int KW = 8,
    parameter int N  = 4,
    localparam int IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0][KW-1:0] tbl,
    input  logic [N-1:0]         en,
    input  logic [KW-1:0]        key,
    output logic                 hit,
    output logic [IW-1:0]        idx
);
    logic [N-1:0] eq;

    for (genvar g = 0; g < N; g++) begin : g_cmp
        assign eq[g] = en[g] && (tbl[g] == key);
    end

    always_comb begin
        hit = 1'b0;
        idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (eq[i]) begin
                hit = 1'b1;
                idx = IW'(i);
            end
        end
    end
endmodule

// File: rtl/slip_enc.sv
// Encode path: separator wrapping and reserved-byte substitution.
module slip_enc #(
    parameter int W = 8,
    parameter int N = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               frame_en,
    input  logic [N-1:0][W-1:0] chars,
    input  logic [N-1:0][W-1:0] seq_hi,
    input  logic [N-1:0][W-1:0] seq_lo,
    input  logic [N-1:0]       en,
    input  logic               in_valid,
    output logic               in_ready,
    input  logic [W-1:0]       in_data,
    input  logic               in_last,
    output logic               out_valid,
    input  logic               out_ready,
    output logic [W-1:0]       out_data,
    output logic               out_last
);
    localparam int IW = (N > 1) ? $clog2(N) : 1;

    typedef struct packed {
        logic         ov;     // output register valid
        logic [W-1:0] od;
        logic         ol;
        logic         pv;     // second escape byte pending
        logic [W-1:0] pd;
        logic         pl;     // pending byte closes the frame
        logic         cl;     // closing separator pending
        logic         op;     // next byte opens a frame
    } enc_st_t;

    enc_st_t st_q, st_d;
    logic          hit;
    logic [IW-1:0] hidx;
    logic          can_load;

    slip_match #(.KW(W), .N(N)) i_match (
        .tbl (chars),
        .en  (en),
        .key (in_data),
        .hit (hit),
        .idx (hidx)
    );

    always_comb begin
        st_d     = st_q;
        can_load = !st_q.ov || out_ready;
        in_ready = can_load && !st_q.pv && !st_q.cl && !(st_q.op && frame_en);
        if (can_load) begin
            st_d.ov = 1'b0;
            st_d.ol = 1'b0;
            if (st_q.pv) begin
                st_d.ov = 1'b1;
                st_d.od = st_q.pd;
                st_d.ol = st_q.pl && !frame_en;
                st_d.pv = 1'b0;
                if (st_q.pl) begin
                    if (frame_en) st_d.cl = 1'b1;
                    else          st_d.op = 1'b1;
                end
            end else if (st_q.cl) begin
                st_d.ov = 1'b1;
                st_d.od = chars[slip_pkg::SLOT_SEP];
                st_d.ol = 1'b1;
                st_d.cl = 1'b0;
                st_d.op = 1'b1;
            end else if (in_valid && st_q.op && frame_en) begin
                st_d.ov = 1'b1;
                st_d.od = chars[slip_pkg::SLOT_SEP];
                st_d.op = 1'b0;
            end else if (in_valid) begin
                st_d.op = 1'b0;
                st_d.ov = 1'b1;
                if (hit) begin
                    st_d.od = seq_hi[hidx];
                    st_d.pv = 1'b1;
                    st_d.pd = seq_lo[hidx];
                    st_d.pl = in_last;
                end else begin
                    st_d.od = in_data;
                    st_d.ol = in_last && !frame_en;
                    if (in_last) begin
                        if (frame_en) st_d.cl = 1'b1;
                        else          st_d.op = 1'b1;
                    end
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q    <= '0;
            st_q.op <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign out_valid = st_q.ov;
    assign out_data  = st_q.od;
    assign out_last  = st_q.ol;
endmodule

// File: rtl/slip_dec.sv
// Decode path: separator removal, pair substitution and frame-end marking.
module slip_dec #(
    parameter int W = 8,
    parameter int N = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               frame_en,
    input  logic [N-1:0][W-1:0] chars,
    input  logic [N-1:0][W-1:0] seq_hi,
    input  logic [N-1:0][W-1:0] seq_lo,
    input  logic [N-1:0]       en,
    input  logic               in_valid,
    output logic               in_ready,
    input  logic [W-1:0]       in_data,
    input  logic               in_last,
    output logic               out_valid,
    input  logic               out_ready,
    output logic [W-1:0]       out_data,
    output logic               out_last,
    output logic               err
);
    localparam int IW = (N > 1) ? $clog2(N) : 1;

    typedef struct packed {
        logic         ov;     // output register
        logic [W-1:0] od;
        logic         ol;
        logic         hv;     // held decoded byte
        logic [W-1:0] hd;
        logic         hf;     // held byte ends the frame
        logic         ev;     // escape-start byte pending
        logic [W-1:0] ed;
        logic         er;     // error pulse
    } dec_st_t;

    dec_st_t st_q, st_d;

    logic [N-1:0][2*W-1:0] pair_tbl;
    logic          start_hit, pair_hit;
    logic [IW-1:0] start_idx, pair_idx;
    logic          can_load, is_sep;
    logic          dv, de;
    logic [W-1:0]  dd;

    for (genvar g = 0; g < N; g++) begin : g_pair
        assign pair_tbl[g] = {seq_hi[g], seq_lo[g]};
    end

    slip_match #(.KW(W), .N(N)) i_start (
        .tbl (seq_hi),
        .en  (en),
        .key (in_data),
        .hit (start_hit),
        .idx (start_idx)
    );

    slip_match #(.KW(2*W), .N(N)) i_pair (
        .tbl (pair_tbl),
        .en  (en),
        .key ({st_q.ed, in_data}),
        .hit (pair_hit),
        .idx (pair_idx)
    );

    assign is_sep = frame_en && (in_data == chars[slip_pkg::SLOT_SEP]);

    always_comb begin
        st_d     = st_q;
        st_d.er  = 1'b0;
        can_load = !st_q.ov || out_ready;
        in_ready = 1'b0;
        dv       = 1'b0;
        de       = 1'b0;
        dd       = in_data;
        if (can_load) begin
            st_d.ov = 1'b0;
            st_d.ol = 1'b0;
            if (st_q.hv && st_q.hf) begin
                st_d.ov = 1'b1;
                st_d.od = st_q.hd;
                st_d.ol = 1'b1;
                st_d.hv = 1'b0;
                st_d.hf = 1'b0;
            end else if (in_valid) begin
                if (st_q.ev) begin
                    st_d.ev = 1'b0;
                    dv      = 1'b1;
                    if (pair_hit) begin
                        in_ready = 1'b1;
                        dd       = chars[pair_idx];
                        de       = in_last;
                    end else begin
                        // release the escape byte alone; current byte is retried
                        st_d.er = 1'b1;
                        dd      = st_q.ed;
                    end
                end else if (is_sep) begin
                    in_ready = 1'b1;
                    if (st_q.hv) begin
                        st_d.ov = 1'b1;
                        st_d.od = st_q.hd;
                        st_d.ol = 1'b1;
                        st_d.hv = 1'b0;
                    end
                end else if (start_hit && !in_last) begin
                    in_ready = 1'b1;
                    st_d.ev  = 1'b1;
                    st_d.ed  = in_data;
                end else begin
                    in_ready = 1'b1;
                    dv       = 1'b1;
                    de       = in_last;
                    st_d.er  = start_hit;
                end
            end
            if (dv) begin
                if (st_q.hv) begin
                    st_d.ov = 1'b1;
                    st_d.od = st_q.hd;
                    st_d.ol = 1'b0;
                end
                st_d.hv = 1'b1;
                st_d.hd = dd;
                st_d.hf = de;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign out_valid = st_q.ov;
    assign out_data  = st_q.od;
    assign out_last  = st_q.ol;
    assign err       = st_q.er;

    logic unused_idx;
    assign unused_idx = ^start_idx;
endmodule

// File: rtl/slip_codec.sv
module slip_codec #(
    parameter int W = slip_pkg::BYTE_W,
    parameter int N = slip_pkg::NUM_CHARS
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cfg_frame_en,
    input  logic [N-1:0][W-1:0] cfg_chars,
    input  logic [N-1:0][W-1:0] cfg_seq_hi,
    input  logic [N-1:0][W-1:0] cfg_seq_lo,
    input  logic [N-1:0]       cfg_enc_en,
    input  logic [N-1:0]       cfg_dec_en,
    input  logic               enc_in_valid,
    output logic               enc_in_ready,
    input  logic [W-1:0]       enc_in_data,
    input  logic               enc_in_last,
    output logic               enc_out_valid,
    input  logic               enc_out_ready,
    output logic [W-1:0]       enc_out_data,
    output logic               enc_out_last,
    input  logic               dec_in_valid,
    output logic               dec_in_ready,
    input  logic [W-1:0]       dec_in_data,
    input  logic               dec_in_last,
    output logic               dec_out_valid,
    input  logic               dec_out_ready,
    output logic [W-1:0]       dec_out_data,
    output logic               dec_out_last,
    output logic               dec_err
);
    slip_enc #(.W(W), .N(N)) i_enc (
        .clk       (clk),
        .rst_n     (rst_n),
        .frame_en  (cfg_frame_en),
        .chars     (cfg_chars),
        .seq_hi    (cfg_seq_hi),
        .seq_lo    (cfg_seq_lo),
        .en        (cfg_enc_en),
        .in_valid  (enc_in_valid),
        .in_ready  (enc_in_ready),
        .in_data   (enc_in_data),
        .in_last   (enc_in_last),
        .out_valid (enc_out_valid),
        .out_ready (enc_out_ready),
        .out_data  (enc_out_data),
        .out_last  (enc_out_last)
    );

    slip_dec #(.W(W), .N(N)) i_dec (
        .clk       (clk),
        .rst_n     (rst_n),
        .frame_en  (cfg_frame_en),
        .chars     (cfg_chars),
        .seq_hi    (cfg_seq_hi),
        .seq_lo    (cfg_seq_lo),
        .en        (cfg_dec_en),
        .in_valid  (dec_in_valid),
        .in_ready  (dec_in_ready),
        .in_data   (dec_in_data),
        .in_last   (dec_in_last),
        .out_valid (dec_out_valid),
        .out_ready (dec_out_ready),
        .out_data  (dec_out_data),
        .out_last  (dec_out_last),
        .err       (dec_err)
    );
endmodule

// File: rtl/slip_codec_chk.sv
module slip_codec_chk #(
    parameter int W = 8,
    parameter int N = 4
) (
    input logic               clk,
    input logic               rst_n,
    input logic               cfg_frame_en,
    input logic [N-1:0][W-1:0] cfg_chars,
    input logic [N-1:0]       cfg_enc_en,
    input logic               enc_in_valid,
    input logic               enc_in_ready,
    input logic [W-1:0]       enc_in_data,
    input logic               enc_out_valid,
    input logic               enc_out_ready,
    input logic [W-1:0]       enc_out_data,
    input logic               enc_out_last,
    input logic               dec_in_ready,
    input logic               dec_out_valid,
    input logic               dec_out_ready,
    input logic [W-1:0]       dec_out_data,
    input logic               dec_out_last
);
    logic esc_hit;
    always_comb begin
        esc_hit = 1'b0;
        for (int i = 0; i < N; i++)
            if (cfg_enc_en[i] && enc_in_data == cfg_chars[i]) esc_hit = 1'b1;
    end

    p_enc_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        enc_out_valid && !enc_out_ready |=> enc_out_valid && $stable(enc_out_data) && $stable(enc_out_last));

    p_dec_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        dec_out_valid && !dec_out_ready |=> dec_out_valid && $stable(dec_out_data) && $stable(dec_out_last));

    p_dec_backpressure_r10: assert property (@(posedge clk) disable iff (!rst_n)
        dec_out_valid && !dec_out_ready |-> !dec_in_ready);

    p_enc_close_sep_r2: assert property (@(posedge clk) disable iff (!rst_n)
        enc_out_valid && enc_out_last && cfg_frame_en |-> enc_out_data == cfg_chars[0]);

    p_enc_escape_stall_r3: assert property (@(posedge clk) disable iff (!rst_n)
        enc_in_valid && enc_in_ready && esc_hit |=> !enc_in_ready);
endmodule

bind slip_codec slip_codec_chk #(.W(W), .N(N)) i_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .cfg_frame_en  (cfg_frame_en),
    .cfg_chars     (cfg_chars),
    .cfg_enc_en    (cfg_enc_en),
    .enc_in_valid  (enc_in_valid),
    .enc_in_ready  (enc_in_ready),
    .enc_in_data   (enc_in_data),
    .enc_out_valid (enc_out_valid),
    .enc_out_ready (enc_out_ready),
    .enc_out_data  (enc_out_data),
    .enc_out_last  (enc_out_last),
    .dec_in_ready  (dec_in_ready),
    .dec_out_valid (dec_out_valid),
    .dec_out_ready (dec_out_ready),
    .dec_out_data  (dec_out_data),
    .dec_out_last  (dec_out_last)
);

// File: tb/test_slip_codec.sv
module test_slip_codec;
    typedef logic [8:0] bq_t[$];   // {last, data}

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2 clk = ~clk;

    logic            cfg_frame_en;
    logic [3:0][7:0] cfg_chars, cfg_seq_hi, cfg_seq_lo;
    logic [3:0]      cfg_enc_en, cfg_dec_en;
    logic enc_in_valid = 0, enc_in_ready, enc_in_last = 0;
    logic [7:0] enc_in_data = 0;
    logic enc_out_valid, enc_out_ready, enc_out_last;
    logic [7:0] enc_out_data;
    logic dec_in_valid = 0, dec_in_ready, dec_in_last = 0;
    logic [7:0] dec_in_data = 0;
    logic dec_out_valid, dec_out_ready, dec_out_last, dec_err;
    logic [7:0] dec_out_data;

    slip_codec i_slip_codec (
        .clk(clk), .rst_n(rst_n), .cfg_frame_en(cfg_frame_en),
        .cfg_chars(cfg_chars), .cfg_seq_hi(cfg_seq_hi), .cfg_seq_lo(cfg_seq_lo),
        .cfg_enc_en(cfg_enc_en), .cfg_dec_en(cfg_dec_en),
        .enc_in_valid(enc_in_valid), .enc_in_ready(enc_in_ready),
        .enc_in_data(enc_in_data), .enc_in_last(enc_in_last),
        .enc_out_valid(enc_out_valid), .enc_out_ready(enc_out_ready),
        .enc_out_data(enc_out_data), .enc_out_last(enc_out_last),
        .dec_in_valid(dec_in_valid), .dec_in_ready(dec_in_ready),
        .dec_in_data(dec_in_data), .dec_in_last(dec_in_last),
        .dec_out_valid(dec_out_valid), .dec_out_ready(dec_out_ready),
        .dec_out_data(dec_out_data), .dec_out_last(dec_out_last),
        .dec_err(dec_err)
    );

    int n_chk = 0, n_fail = 0;
    int cyc = 0;
    logic bp = 0;
    logic done = 0;
    bq_t enc_src, dec_src, enc_cap, dec_cap, exp_q;
    int  stamps[$];
    int  err_cycles = 0;
    logic e_stall = 0, d_stall = 0;
    logic [8:0] e_prev, d_prev;

    always @(posedge clk) cyc <= cyc + 1;

    initial begin
        enc_out_ready = 1;
        dec_out_ready = 1;
        forever begin
            @(posedge clk);
            #1;
            enc_out_ready = bp ? ~enc_out_ready : 1'b1;
            dec_out_ready = bp ? ~dec_out_ready : 1'b1;
        end
    end

    // Sinks and stall-stability checks on the falling edge
    always @(negedge clk) begin
        if (rst_n) begin
            if (e_stall) begin
                n_chk++;
                if (!(enc_out_valid && {enc_out_last, enc_out_data} == e_prev)) begin
                    n_fail++;
                    $display("FAIL R10 enc stall: act %b/%h exp 1/%h", enc_out_valid, {enc_out_last, enc_out_data}, e_prev);
                end
            end
            if (d_stall) begin
                n_chk++;
                if (!(dec_out_valid && {dec_out_last, dec_out_data} == d_prev)) begin
                    n_fail++;
                    $display("FAIL R10 dec stall: act %b/%h exp 1/%h", dec_out_valid, {dec_out_last, dec_out_data}, d_prev);
                end
            end
            e_stall = enc_out_valid && !enc_out_ready;
            e_prev  = {enc_out_last, enc_out_data};
            d_stall = dec_out_valid && !dec_out_ready;
            d_prev  = {dec_out_last, dec_out_data};
            if (enc_out_valid && enc_out_ready) enc_cap.push_back({enc_out_last, enc_out_data});
            if (dec_out_valid && dec_out_ready) dec_cap.push_back({dec_out_last, dec_out_data});
            if (dec_err) err_cycles++;
        end
    end

    task automatic check(string tag, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: act %0h exp %0h", tag, act, exp);
        end
    endtask

    task automatic cmp_q(string tag, bq_t act, bq_t exp);
        check({tag, " length"}, act.size(), exp.size());
        for (int i = 0; i < exp.size() && i < act.size(); i++)
            check($sformatf("%s byte %0d", tag, i), int'(act[i]), int'(exp[i]));
    endtask

    task automatic set_defaults();
        cfg_frame_en = 1;
        cfg_chars  = {8'h13, 8'h11, 8'hDB, 8'hC0};
        cfg_seq_hi = {8'hDB, 8'hDB, 8'hDB, 8'hDB};
        cfg_seq_lo = {8'hDF, 8'hDE, 8'hDD, 8'hDC};
        cfg_enc_en = 4'hF;
        cfg_dec_en = 4'hF;
    endtask

    // Encoder expectation from R2..R5
    function automatic bq_t enc_model(bq_t src);
        bq_t o;
        logic open = 1;
        foreach (src[k]) begin
            logic [7:0] b = src[k][7:0];
            logic l = src[k][8];
            int hit = -1;
            if (open && cfg_frame_en) o.push_back({1'b0, cfg_chars[0]});
            open = 0;
            for (int i = 3; i >= 0; i--)
                if (cfg_enc_en[i] && cfg_chars[i] == b) hit = i;
            if (hit >= 0) begin
                o.push_back({1'b0, cfg_seq_hi[hit]});
                o.push_back({l && !cfg_frame_en, cfg_seq_lo[hit]});
            end else begin
                o.push_back({l && !cfg_frame_en, b});
            end
            if (l) begin
                if (cfg_frame_en) o.push_back({1'b1, cfg_chars[0]});
                open = 1;
            end
        end
        return o;
    endfunction

    task automatic drive_enc();
        stamps.delete();
        foreach (enc_src[k]) begin
            logic fired = 0;
            enc_in_valid = 1;
            enc_in_data  = enc_src[k][7:0];
            enc_in_last  = enc_src[k][8];
            while (!fired) begin
                @(negedge clk);
                if (enc_in_ready) begin
                    fired = 1;
                    stamps.push_back(cyc);
                end
                @(posedge clk);
                #1;
            end
        end
        enc_in_valid = 0;
        enc_in_last  = 0;
    endtask

    task automatic drive_dec();
        foreach (dec_src[k]) begin
            logic fired = 0;
            dec_in_valid = 1;
            dec_in_data  = dec_src[k][7:0];
            dec_in_last  = dec_src[k][8];
            while (!fired) begin
                @(negedge clk);
                if (dec_in_ready) fired = 1;
                @(posedge clk);
                #1;
            end
        end
        dec_in_valid = 0;
        dec_in_last  = 0;
    endtask

    task automatic run_enc(string tag, bq_t src);
        enc_src = src;
        enc_cap.delete();
        drive_enc();
        repeat (12) @(posedge clk);
        #1;
        cmp_q(tag, enc_cap, enc_model(src));
    endtask

    task automatic run_dec(string tag, bq_t src, bq_t exp, int exp_err);
        dec_src = src;
        dec_cap.delete();
        err_cycles = 0;
        drive_dec();
        repeat (12) @(posedge clk);
        #1;
        cmp_q(tag, dec_cap, exp);
        check({tag, " error cycles"}, err_cycles, exp_err);
    endtask

    task automatic t_reset();
        @(negedge clk);
        check("R1 enc_out_valid", int'(enc_out_valid), 0);
        check("R1 dec_out_valid", int'(dec_out_valid), 0);
        check("R1 dec_err", int'(dec_err), 0);
    endtask

    task automatic t_enc_frame();   // R2
        run_enc("R2 plain frame", '{9'h001, 9'h002, 9'h103});
        exp_q = '{9'h0C0, 9'h001, 9'h002, 9'h003, 9'h1C0};
        cmp_q("R2 literal frame", enc_cap, exp_q);
    endtask

    task automatic t_enc_escape();  // R3
        run_enc("R3 all reserved", '{9'h0C0, 9'h0DB, 9'h011, 9'h013, 9'h155});
        exp_q = '{9'h0C0, 9'h0DB, 9'h0DC, 9'h0DB, 9'h0DD, 9'h0DB, 9'h0DE,
                  9'h0DB, 9'h0DF, 9'h055, 9'h1C0};
        cmp_q("R3 literal escape", enc_cap, exp_q);
        run_enc("R3 stall timing", '{9'h055, 9'h0C0, 9'h166});
        check("R3 gap plain byte", stamps[1] - stamps[0], 1);
        check("R3 gap after escape", stamps[2] - stamps[1], 2);
    endtask

    task automatic t_enc_disabled(); // R4
        cfg_enc_en = 4'b0101;
        run_enc("R4 disabled chars", '{9'h011, 9'h013, 9'h1DB});
        exp_q = '{9'h0C0, 9'h0DB, 9'h0DE, 9'h013, 9'h0DB, 9'h1C0};
        cmp_q("R4 literal", enc_cap, exp_q);
        set_defaults();
    endtask

    task automatic t_enc_noframe(); // R5
        cfg_frame_en = 0;
        run_enc("R5 no framing", '{9'h001, 9'h0C0, 9'h102, 9'h113});
        exp_q = '{9'h001, 9'h0DB, 9'h0DC, 9'h102, 9'h0DB, 9'h1DF};
        cmp_q("R5 literal", enc_cap, exp_q);
        set_defaults();
    endtask

    task automatic t_enc_bp();      // R10
        bp = 1;
        run_enc("R10 enc backpressure", '{9'h0C0, 9'h021, 9'h011, 9'h122, 9'h033, 9'h1DB});
        bp = 0;
    endtask

    task automatic t_dec_basic();   // R6 R7
        run_dec("R6 R7 decode",
            '{9'h0C0, 9'h0C0, 9'h041, 9'h0DB, 9'h0DC, 9'h0DB, 9'h0DD, 9'h042, 9'h0C0,
              9'h0C0, 9'h043, 9'h0DB, 9'h0DE, 9'h0DB, 9'h0DF, 9'h1C0},
            '{9'h041, 9'h0C0, 9'h0DB, 9'h142, 9'h043, 9'h011, 9'h113}, 0);
    endtask

    task automatic t_dec_err();     // R8
        run_dec("R8 unknown pair", '{9'h0C0, 9'h041, 9'h0DB, 9'h099, 9'h042, 9'h1C0},
            '{9'h041, 9'h0DB, 9'h099, 9'h142}, 1);
    endtask

    task automatic t_dec_disabled(); // R9
        cfg_dec_en = 4'b1011;
        run_dec("R9 xon disabled", '{9'h0C0, 9'h0DB, 9'h0DE, 9'h044, 9'h1C0},
            '{9'h0DB, 9'h0DE, 9'h144}, 1);
        cfg_dec_en = 4'b0000;
        run_dec("R9 all disabled", '{9'h0C0, 9'h0DB, 9'h0DD, 9'h1C0},
            '{9'h0DB, 9'h1DD}, 0);
        set_defaults();
    endtask

    task automatic t_sep_cfg();     // R11
        cfg_chars[0] = 8'h7E;
        run_enc("R11 enc custom separator", '{9'h07E, 9'h1C0});
        exp_q = '{9'h07E, 9'h0DB, 9'h0DC, 9'h0C0, 9'h17E};
        cmp_q("R11 enc literal", enc_cap, exp_q);
        run_dec("R11 dec custom separator", '{9'h07E, 9'h0C0, 9'h0DB, 9'h0DC, 9'h17E},
            '{9'h0C0, 9'h17E}, 0);
        set_defaults();
    endtask

    task automatic t_dec_noframe(); // R12
        cfg_frame_en = 0;
        run_dec("R12 last flag ends frame", '{9'h051, 9'h0C0, 9'h152, 9'h053, 9'h154},
            '{9'h051, 9'h0C0, 9'h152, 9'h053, 9'h154}, 0);
        set_defaults();
    endtask

    task automatic t_dec_bp();      // R10
        bp = 1;
        run_dec("R10 dec backpressure",
            '{9'h0C0, 9'h061, 9'h0DB, 9'h0DD, 9'h062, 9'h0C0, 9'h063, 9'h1C0},
            '{9'h061, 9'h0DB, 9'h162, 9'h163}, 0);
        bp = 0;
    endtask

    initial begin
        set_defaults();
        repeat (4) @(posedge clk);
        #1 rst_n = 1;
        t_reset();
        t_enc_frame();
        t_enc_escape();
        t_enc_disabled();
        t_enc_noframe();
        t_enc_bp();
        t_dec_basic();
        t_dec_err();
        t_dec_disabled();
        t_sep_cfg();
        t_dec_noframe();
        t_dec_bp();
        if (!done) begin
            done = 1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: act timeout exp completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end
endmodule